// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store RISC Core

This block is a small processor core that completes one instruction per clock. In each cycle it presents the program counter on an instruction port and receives a 32-bit word back in the same cycle. It decodes that word as a register-format or an immediate-format instruction, reads two operands from a 32-entry register file, and computes a result. At the closing clock edge it commits the register write, the data store and the next program counter.

The supported operations are register add and subtract, and, or, xor and nor. The immediate operations are add-immediate, or-immediate and load-upper-immediate. The shifts come in fixed-amount and register-amount forms, both logical and arithmetic. Memory access is a word load and a word store through a combinational data port. Control flow covers equal and not-equal branches, an absolute jump and a jump through a register. A signed overflow on any add or subtract raises a sticky exception flag, and the offending write is dropped.

The surrounding system supplies both memories as combinational reads, with an address presented and data returned in the same cycle.

Top module: `risc_core`

## Requirements
- R1: While rst_n is low, the instruction address is 0x00400000 and exc_overflow is 0. The core fetches from 0x00400000 in the first cycle after reset is released.
- R2: An instruction that does not redirect control flow advances the instruction address by 4 at the next clock edge.
- R3: An instruction with opcode bits [31:26] equal to 0 is register-format: rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0]. The funct values add=0x20, sub=0x22, and=0x24, or=0x25, xor=0x26 and nor=0x27 write the result of rs op rt to rd.
- R4: Add-immediate (opcode 0x08) writes rs + sign-extended imm[15:0] to rt. On signed overflow of add, sub or add-immediate, the destination is left unchanged and exc_overflow goes high after the clock edge. The flag then stays high until reset.
- R5: Register 0 always reads as zero, and writes to it have no effect.
- R6: Load-upper (opcode 0x0F) writes imm into rt bits 31:16 and clears bits 15:0. Or-immediate (opcode 0x0D) ORs rs with the zero-extended imm into rt.
- R7: The funct values sll=0x00, srl=0x02 and sra=0x03 shift rt by shamt into rd. sra fills vacated bits with bit 31 of rt.
- R8: The funct values sllv=0x04, srlv=0x06 and srav=0x07 shift rt by rs[4:0] into rd. srav fills vacated bits with bit 31 of rt.
- R9: Branch-equal (opcode 0x04) and branch-not-equal (opcode 0x05) compare rs with rt. When the condition holds, the next address is PC+4 plus the sign-extended imm shifted left by 2. Otherwise it is PC+4.
- R10: Jump (opcode 0x02) sets the next address to {PC+4[31:28], instr[25:0], 2'b00}. Register jump (funct 0x08) sets it to rs with bits 1:0 forced to zero.
- R11: Word load (opcode 0x23) and word store (opcode 0x2B) use the address rs + sign-extended imm. A store drives dmem_we high with rt on dmem_wdata and writes no register. A load writes dmem_rdata to rt and keeps dmem_we low.
- R12: Any other opcode or funct writes no register, issues no store and advances the address by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data memory word address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| exc_overflow | output | 1 | Sticky signed-overflow exception flag |

## Verification
The data port outputs depend combinationally on the presented instruction, so they are due in the same cycle the word is driven. The next instruction address and the overflow flag change at the following rising edge. A register write is also committed at that edge, but it only becomes visible when a later store places the register on dmem_wdata. The bench therefore drives each instruction just after a falling edge. It samples the store outputs a short delay later, in the same cycle, and samples the address and the flag one falling edge after the instruction that changed them.

// File: rtl/risc_pkg.sv
package risc_pkg;

   localparam int unsigned WORD_W = 32;

   localparam logic [5:0] OPC_REG   = 6'h00;
   localparam logic [5:0] OPC_JUMP  = 6'h02;
   localparam logic [5:0] OPC_BREQ  = 6'h04;
   localparam logic [5:0] OPC_BRNE  = 6'h05;
   localparam logic [5:0] OPC_ADDI  = 6'h08;
   localparam logic [5:0] OPC_ORI   = 6'h0D;
   localparam logic [5:0] OPC_LUPR  = 6'h0F;
   localparam logic [5:0] OPC_LDW   = 6'h23;
   localparam logic [5:0] OPC_STW   = 6'h2B;

   localparam logic [5:0] FUN_SLL   = 6'h00;
   localparam logic [5:0] FUN_SRL   = 6'h02;
   localparam logic [5:0] FUN_SRA   = 6'h03;
   localparam logic [5:0] FUN_SLLV  = 6'h04;
   localparam logic [5:0] FUN_SRLV  = 6'h06;
   localparam logic [5:0] FUN_SRAV  = 6'h07;
   localparam logic [5:0] FUN_JREG  = 6'h08;
   localparam logic [5:0] FUN_ADD   = 6'h20;
   localparam logic [5:0] FUN_SUB   = 6'h22;
   localparam logic [5:0] FUN_AND   = 6'h24;
   localparam logic [5:0] FUN_OR    = 6'h25;
   localparam logic [5:0] FUN_XOR   = 6'h26;
   localparam logic [5:0] FUN_NOR   = 6'h27;

   typedef enum logic [3:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
      ALU_SHL, ALU_SHR, ALU_SAR, ALU_UPPER
   } alu_op_e;

   typedef enum logic [1:0] {
      BR_NONE, BR_EQ, BR_NE
   } br_kind_e;

   typedef struct packed {
      alu_op_e  alu_op;
      logic     b_is_imm;
      logic     imm_zext;
      logic     a_is_rt;
      logic     shamt_reg;
      logic     reg_we;
      logic     dst_rd;
      logic     mem_we;
      logic     mem_rd;
      logic     trap_ovf;
      br_kind_e br;
      logic     jump;
      logic     jump_reg;
   } ctrl_t;

endpackage

// File: rtl/risc_decode.sv
module risc_decode
   import risc_pkg::*;
(
   input  logic [WORD_W-1:0] instr,
   output ctrl_t             ctrl
);

   logic [5:0] opc;
   logic [5:0] fun;

   assign opc = instr[31:26];
   assign fun = instr[5:0];

   always_comb begin
      ctrl = '0;
      unique case (opc)
         OPC_REG: begin
            ctrl.dst_rd = 1'b1;
            unique case (fun)
               FUN_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.reg_we = 1'b1; ctrl.trap_ovf = 1'b1; end
               FUN_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.reg_we = 1'b1; ctrl.trap_ovf = 1'b1; end
               FUN_AND: begin ctrl.alu_op = ALU_AND; ctrl.reg_we = 1'b1; end
               FUN_OR:  begin ctrl.alu_op = ALU_OR;  ctrl.reg_we = 1'b1; end
               FUN_XOR: begin ctrl.alu_op = ALU_XOR; ctrl.reg_we = 1'b1; end
               FUN_NOR: begin ctrl.alu_op = ALU_NOR; ctrl.reg_we = 1'b1; end
               FUN_SLL: begin ctrl.alu_op = ALU_SHL; ctrl.a_is_rt = 1'b1; ctrl.reg_we = 1'b1; end
               FUN_SRL: begin ctrl.alu_op = ALU_SHR; ctrl.a_is_rt = 1'b1; ctrl.reg_we = 1'b1; end
               FUN_SRA: begin ctrl.alu_op = ALU_SAR; ctrl.a_is_rt = 1'b1; ctrl.reg_we = 1'b1; end
               FUN_SLLV: begin
                  ctrl.alu_op = ALU_SHL; ctrl.a_is_rt = 1'b1; ctrl.shamt_reg = 1'b1; ctrl.reg_we = 1'b1;
               end
               FUN_SRLV: begin
                  ctrl.alu_op = ALU_SHR; ctrl.a_is_rt = 1'b1; ctrl.shamt_reg = 1'b1; ctrl.reg_we = 1'b1;
               end
               FUN_SRAV: begin
                  ctrl.alu_op = ALU_SAR; ctrl.a_is_rt = 1'b1; ctrl.shamt_reg = 1'b1; ctrl.reg_we = 1'b1;
               end
               FUN_JREG: ctrl.jump_reg = 1'b1;
               default:  ctrl.dst_rd = 1'b1;
            endcase
         end
         OPC_ADDI: begin
            ctrl.alu_op = ALU_ADD; ctrl.b_is_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.trap_ovf = 1'b1;
         end
         OPC_ORI: begin
            ctrl.alu_op = ALU_OR; ctrl.b_is_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.reg_we = 1'b1;
         end
         OPC_LUPR: begin
            ctrl.alu_op = ALU_UPPER; ctrl.b_is_imm = 1'b1; ctrl.reg_we = 1'b1;
         end
         OPC_LDW: begin
            ctrl.alu_op = ALU_ADD; ctrl.b_is_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.mem_rd = 1'b1;
         end
         OPC_STW: begin
            ctrl.alu_op = ALU_ADD; ctrl.b_is_imm = 1'b1; ctrl.mem_we = 1'b1;
         end
         OPC_BREQ: ctrl.br = BR_EQ;
         OPC_BRNE: ctrl.br = BR_NE;
         OPC_JUMP: ctrl.jump = 1'b1;
         default:  ctrl = '0;
      endcase
   end

endmodule

// File: rtl/risc_alu.sv
module risc_alu
   import risc_pkg::*;
#(
   parameter int unsigned W          = 32,
   parameter int unsigned SHIFT_IMPL = 1,
   localparam int unsigned SH_W      = $clog2(W)
) (
   input  alu_op_e         op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic [SH_W-1:0] shamt,
   output logic [W-1:0]    y,
   output logic            ovf
);

   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("risc_alu: W must be even and at least 4");
   end
   if (SHIFT_IMPL > 1) begin : g_bad_impl
      $error("risc_alu: SHIFT_IMPL must be 0 or 1");
   end

   logic [W-1:0] shl_y, shr_y, sar_y;
   logic [W-1:0] sum, diff;
   logic         add_ovf, sub_ovf;

   if (SHIFT_IMPL == 0) begin : g_shift_op
      assign shl_y = a << shamt;
      assign shr_y = a >> shamt;
      assign sar_y = $signed(a) >>> shamt;
   end else begin : g_shift_barrel
      logic [W-1:0] l_st [SH_W+1];
      logic [W-1:0] r_st [SH_W+1];
      logic [W-1:0] s_st [SH_W+1];
      assign l_st[0] = a;
      assign r_st[0] = a;
      assign s_st[0] = a;
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         localparam int unsigned D = 1 << k;
         assign l_st[k+1] = shamt[k] ? {l_st[k][W-1-D:0], {D{1'b0}}} : l_st[k];
         assign r_st[k+1] = shamt[k] ? {{D{1'b0}}, r_st[k][W-1:D]}   : r_st[k];
         assign s_st[k+1] = shamt[k] ? {{D{a[W-1]}}, s_st[k][W-1:D]} : s_st[k];
      end
      assign shl_y = l_st[SH_W];
      assign shr_y = r_st[SH_W];
      assign sar_y = s_st[SH_W];
   end

   assign sum     = a + b;
   assign diff    = a - b;
   assign add_ovf = (a[W-1] == b[W-1]) && (sum[W-1]  != a[W-1]);
   assign sub_ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);

   always_comb begin
      ovf = 1'b0;
      unique case (op)
         ALU_ADD:   begin y = sum;  ovf = add_ovf; end
         ALU_SUB:   begin y = diff; ovf = sub_ovf; end
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_XOR:   y = a ^ b;
         ALU_NOR:   y = ~(a | b);
         ALU_SHL:   y = shl_y;
         ALU_SHR:   y = shr_y;
         ALU_SAR:   y = sar_y;
         ALU_UPPER: y = {b[W/2-1:0], {(W/2){1'b0}}};
         default:   y = '0;
      endcase
   end

endmodule

// File: rtl/risc_regfile.sv
module risc_regfile #(
   parameter int unsigned W     = 32,
   parameter int unsigned NREGS = 32,
   localparam int unsigned AW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_data,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);

   if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_depth
      $error("risc_regfile: NREGS must be a power of two, at least 2");
   end

   logic [W-1:0] mem [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      end else if (we && (wa != '0)) begin
         mem[wa] <= wd;
      end
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];

   AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_addr == '0) |-> (ra_data == '0)); // R5

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (wa != '0)) |=> (mem[$past(wa)] == $past(wd))); // R3

endmodule

// File: rtl/risc_core.sv
module risc_core
   import risc_pkg::*;
#(
   parameter logic [31:0]  RESET_PC   = 32'h0040_0000,
   parameter int unsigned  NREGS      = 32,
   parameter int unsigned  SHIFT_IMPL = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic        dmem_we,
   input  logic [31:0] dmem_rdata,
   output logic        exc_overflow
);

   localparam int unsigned W    = WORD_W;
   localparam int unsigned AW   = $clog2(NREGS);
   localparam int unsigned SH_W = $clog2(W);
   localparam int unsigned HW   = W / 2;

   if (W != 32) begin : g_bad_word
      $error("risc_core: the instruction encoding needs a 32-bit word");
   end
   if (NREGS != 32) begin : g_bad_regs
      $error("risc_core: register fields are 5 bits, NREGS must be 32");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
      $error("risc_core: RESET_PC must be word aligned");
   end

   logic [W-1:0]    pc_q, pc_nxt, pc_plus4;
   logic [W-1:0]    instr;
   ctrl_t           ctrl;
   logic [AW-1:0]   f_rs, f_rt, f_rd, wa;
   logic [SH_W-1:0] f_shamt, sh_amt;
   logic [HW-1:0]   f_imm;
   logic [W-1:0]    rs_val, rt_val, imm_ext, alu_a, alu_b, alu_y, wb_data;
   logic [W-1:0]    br_target, jmp_target, jr_target;
   logic            alu_ovf, ovf_now, rf_we, taken, redirect, ovf_q;

   assign instr   = imem_rdata;
   assign f_rs    = instr[25:21];
   assign f_rt    = instr[20:16];
   assign f_rd    = instr[15:11];
   assign f_shamt = instr[10:6];
   assign f_imm   = instr[15:0];

   risc_decode u_decode (
      .instr (instr),
      .ctrl  (ctrl)
   );

   risc_regfile #(.W(W), .NREGS(NREGS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_addr (f_rs),
      .ra_data (rs_val),
      .rb_addr (f_rt),
      .rb_data (rt_val),
      .we      (rf_we),
      .wa      (wa),
      .wd      (wb_data)
   );

   assign imm_ext = ctrl.imm_zext ? {{HW{1'b0}}, f_imm} : {{HW{f_imm[HW-1]}}, f_imm};
   assign alu_a   = ctrl.a_is_rt  ? rt_val : rs_val;
   assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;
   assign sh_amt  = ctrl.shamt_reg ? rs_val[SH_W-1:0] : f_shamt;

   risc_alu #(.W(W), .SHIFT_IMPL(SHIFT_IMPL)) u_alu (
      .op    (ctrl.alu_op),
      .a     (alu_a),
      .b     (alu_b),
      .shamt (sh_amt),
      .y     (alu_y),
      .ovf   (alu_ovf)
   );

   assign ovf_now = ctrl.trap_ovf & alu_ovf;
   assign rf_we   = ctrl.reg_we & ~ovf_now;
   assign wa      = ctrl.dst_rd ? f_rd : f_rt;
   assign wb_data = ctrl.mem_rd ? dmem_rdata : alu_y;

   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_val;
   assign dmem_we    = ctrl.mem_we;

   assign pc_plus4   = pc_q + W'(4);
   assign br_target  = pc_plus4 + {imm_ext[W-3:0], 2'b00};
   assign jmp_target = {pc_plus4[W-1:28], instr[25:0], 2'b00};
   assign jr_target  = {rs_val[W-1:2], 2'b00};

   always_comb begin
      unique case (ctrl.br)
         BR_EQ:   taken = (rs_val == rt_val);
         BR_NE:   taken = (rs_val != rt_val);
         default: taken = 1'b0;
      endcase
   end

   assign redirect = taken | ctrl.jump | ctrl.jump_reg;

   always_comb begin
      if (ctrl.jump_reg)  pc_nxt = jr_target;
      else if (ctrl.jump) pc_nxt = jmp_target;
      else if (taken)     pc_nxt = br_target;
      else                pc_nxt = pc_plus4;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         ovf_q <= 1'b0;
      end else begin
         pc_q  <= pc_nxt;
         ovf_q <= ovf_q | ovf_now;
      end
   end

   assign imem_addr    = pc_q;
   assign exc_overflow = ovf_q;

   AST_SEQUENTIAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> (pc_q == $past(pc_q) + W'(4))); // R2

   AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q[1:0] == 2'b00); // R10

   AST_OVF_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_now |=> exc_overflow); // R4

   AST_OVF_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      exc_overflow |=> exc_overflow); // R4

   AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> !rf_we); // R11

endmodule

// File: tb/tb_risc_core.sv
module tb_risc_core;

   localparam logic [31:0] BOOT   = 32'h0040_0000;
   localparam logic [31:0] RD_MIX = 32'hC3A5_0F96;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr;
   logic [31:0] imem_rdata = 32'h0;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, exc_overflow;

   int          checks = 0;
   int          failures = 0;
   logic [31:0] exp_pc = BOOT;
   string       pc_tag = "R1";

   always #4 clk = ~clk;

   assign dmem_rdata = dmem_addr ^ RD_MIX;

   risc_core dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .imem_addr    (imem_addr),
      .imem_rdata   (imem_rdata),
      .dmem_addr    (dmem_addr),
      .dmem_wdata   (dmem_wdata),
      .dmem_we      (dmem_we),
      .dmem_rdata   (dmem_rdata),
      .exc_overflow (exc_overflow)
   );

   function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
      return {6'h00, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] ref_r(input logic [5:0] fn, input logic [31:0] a, b, input logic [4:0] sh);
      case (fn)
         6'h20: return a + b;
         6'h22: return a - b;
         6'h24: return a & b;
         6'h25: return a | b;
         6'h26: return a ^ b;
         6'h27: return ~(a | b);
         6'h00: return b << sh;
         6'h02: return b >> sh;
         6'h03: return 32'($signed(b) >>> sh);
         6'h04: return b << a[4:0];
         6'h06: return b >> a[4:0];
         6'h07: return 32'($signed(b) >>> a[4:0]);
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic ref_ovf(input logic [5:0] fn, input logic [31:0] a, b);
      logic [31:0] s;
      if (fn == 6'h20) begin
         s = a + b;
         return (a[31] == b[31]) && (s[31] != a[31]);
      end
      if (fn == 6'h22) begin
         s = a - b;
         return (a[31] != b[31]) && (s[31] != a[31]);
      end
      return 1'b0;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic issue(input logic [31:0] ins);
      chk(imem_addr, exp_pc, pc_tag);
      imem_rdata = ins;
      #1;
   endtask

   task automatic retire(input logic [31:0] nxt, input string tag);
      @(negedge clk);
      exp_pc = nxt;
      pc_tag = tag;
   endtask

   task automatic exec(input logic [31:0] ins, input logic [31:0] nxt, input string tag);
      issue(ins);
      retire(nxt, tag);
   endtask

   task automatic seq(input logic [31:0] ins);
      exec(ins, exp_pc + 32'd4, "R2");
   endtask

   task automatic load(input logic [4:0] r, input logic [31:0] v);
      seq(enc_i(6'h0F, 5'd0, r, v[31:16]));
      seq(enc_i(6'h0D, r, r, v[15:0]));
   endtask

   task automatic store_chk(input logic [4:0] r, input logic [31:0] expv, input string tag);
      issue(enc_i(6'h2B, 5'd0, r, 16'h0100));
      chk({31'b0, dmem_we}, 32'd1, tag);
      chk(dmem_addr, 32'h0000_0100, tag);
      chk(dmem_wdata, expv, tag);
      retire(exp_pc + 32'd4, "R2");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      imem_rdata = 32'h0;
      repeat (3) @(negedge clk);
      chk(imem_addr, BOOT, "R1");
      chk({31'b0, exc_overflow}, 32'd0, "R1");
      rst_n = 1'b1;
      exp_pc = BOOT;
      pc_tag = "R1";
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", imem_addr, exp_pc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] a, b, expv, tgt;
      logic [25:0] idx;
      void'($urandom(32'd7321));

      do_reset();

      // R3, R4: add-immediate with positive and negative values, then register add
      seq(32'h2003_0007);
      seq(32'h2004_0009);
      seq(32'h0064_2820);
      store_chk(5'd5, 32'd16, "R3");
      seq(enc_i(6'h08, 5'd0, 5'd6, 16'hFFFD));
      store_chk(5'd6, 32'hFFFF_FFFD, "R4");

      // R5: writes to register 0 are dropped
      seq(enc_i(6'h08, 5'd0, 5'd0, 16'h0005));
      store_chk(5'd0, 32'h0, "R5");
      seq(enc_r(5'd3, 5'd4, 5'd0, 5'd0, 6'h20));
      store_chk(5'd0, 32'h0, "R5");

      // R6: upper-immediate and zero-extended or-immediate
      load(5'd7, 32'hFEDC_8765);
      store_chk(5'd7, 32'hFEDC_8765, "R6");
      seq(enc_i(6'h0D, 5'd0, 5'd8, 16'h8765));
      store_chk(5'd8, 32'h0000_8765, "R6");
      seq(enc_i(6'h0F, 5'd0, 5'd8, 16'hABCD));
      store_chk(5'd8, 32'hABCD_0000, "R6");

      // R3, R7, R8: random operands over all register-format operations
      for (int t = 0; t < 90; t++) begin
         int          sel;
         logic [5:0]  fn;
         logic [4:0]  sh;
         logic [31:0] sent;
         string       tg;
         a    = $urandom;
         b    = $urandom;
         sel  = int'($urandom_range(0, 11));
         sh   = 5'($urandom_range(0, 31));
         sent = 32'h5EED_0000 + 32'(t);
         if ((t % 10) == 0) begin
            a = 32'h8000_0000;
            sh = 5'd31;
         end
         case (sel)
            0: fn = 6'h20;  1: fn = 6'h22;  2: fn = 6'h24;  3: fn = 6'h25;
            4: fn = 6'h26;  5: fn = 6'h27;  6: fn = 6'h00;  7: fn = 6'h02;
            8: fn = 6'h03;  9: fn = 6'h04; 10: fn = 6'h06; default: fn = 6'h07;
         endcase
         tg = (sel < 6) ? "R3" : ((sel < 9) ? "R7" : "R8");
         load(5'd1, a);
         load(5'd2, b);
         load(5'd3, sent);
         seq(enc_r(5'd1, 5'd2, 5'd3, sh, fn));
         expv = ref_ovf(fn, a, b) ? sent : ref_r(fn, a, b, sh);
         store_chk(5'd3, expv, tg);
      end

      // R9: conditional branches, forward and backward, taken and not taken
      load(5'd1, 32'h0000_1234);
      load(5'd2, 32'h0000_1234);
      exec(enc_i(6'h04, 5'd1, 5'd2, 16'h0003), exp_pc + 32'd16, "R9");
      exec(enc_i(6'h05, 5'd1, 5'd2, 16'h0005), exp_pc + 32'd4, "R9");
      load(5'd2, 32'h0000_0099);
      exec(enc_i(6'h05, 5'd1, 5'd2, 16'hFFFE), exp_pc - 32'd4, "R9");
      exec(enc_i(6'h04, 5'd1, 5'd2, 16'h0007), exp_pc + 32'd4, "R9");
      seq(32'h0);

      // R10: absolute jump and register jump
      idx = 26'h012_3456;
      tgt = exp_pc + 32'd4;
      exec({6'h02, idx}, {tgt[31:28], idx, 2'b00}, "R10");
      load(5'd10, 32'h0040_2013);
      exec(enc_r(5'd10, 5'd0, 5'd0, 5'd0, 6'h08), 32'h0040_2010, "R10");
      seq(32'h0);

      // R11: word load and store with positive and negative offsets
      load(5'd1, 32'h1000_0000);
      issue(enc_i(6'h23, 5'd1, 5'd9, 16'h0010));
      chk({31'b0, dmem_we}, 32'd0, "R11");
      chk(dmem_addr, 32'h1000_0010, "R11");
      retire(exp_pc + 32'd4, "R2");
      store_chk(5'd9, 32'h1000_0010 ^ RD_MIX, "R11");
      load(5'd12, 32'hFFFF_FFFF);
      load(5'd13, 32'h0004_0014);
      issue(enc_i(6'h2B, 5'd13, 5'd12, 16'hFFF8));
      chk({31'b0, dmem_we}, 32'd1, "R11");
      chk(dmem_addr, 32'h0004_000C, "R11");
      chk(dmem_wdata, 32'hFFFF_FFFF, "R11");
      retire(exp_pc + 32'd4, "R2");

      // R12: unrecognized opcode and funct have no effect
      load(5'd3, 32'hABCD_1234);
      issue(enc_i(6'h3F, 5'd0, 5'd3, 16'h5555));
      chk({31'b0, dmem_we}, 32'd0, "R12");
      retire(exp_pc + 32'd4, "R12");
      issue(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h3E));
      chk({31'b0, dmem_we}, 32'd0, "R12");
      retire(exp_pc + 32'd4, "R12");
      store_chk(5'd3, 32'hABCD_1234, "R12");

      // R4: overflow keeps the destination and sets a sticky flag
      do_reset();
      load(5'd1, 32'h7FFF_FFFF);
      load(5'd3, 32'h0000_0011);
      chk({31'b0, exc_overflow}, 32'd0, "R4");
      seq(enc_i(6'h08, 5'd1, 5'd3, 16'h0001));
      chk({31'b0, exc_overflow}, 32'd1, "R4");
      store_chk(5'd3, 32'h0000_0011, "R4");
      load(5'd5, 32'h8000_0000);
      load(5'd6, 32'h0000_0001);
      load(5'd4, 32'h0000_0022);
      seq(enc_r(5'd5, 5'd6, 5'd4, 5'd0, 6'h22));
      store_chk(5'd4, 32'h0000_0022, "R4");
      chk({31'b0, exc_overflow}, 32'd1, "R4");
      do_reset();
      seq(32'h0);
      chk({31'b0, exc_overflow}, 32'd0, "R4");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule